// File: doc/BRIEF.md
# Multi-Page-Size Associative Translation Buffer

This block translates 64-bit virtual addresses into 41-bit physical page addresses with a fully associative buffer of translation entries. Every entry carries its own page-size code, so 8 KB, 64 KB, 512 KB and 4 MB mappings live side by side. Each entry compares the incoming address under the mask its size implies. A match also needs the entry to be global, or its 13-bit context to equal the context chosen for the access.

A lookup carries an access kind, a user/privileged flag and a context selector. One cycle later the block returns one outcome: success with permissions, a miss, an access fault or a write-protection fault. On a fault it records a fault status word and the faulting address. On a miss or a fault it loads a tag-access word, which a refill handler elsewhere would consume. A plain write port installs entries. When translation is switched off, addresses pass straight through.

A two-state machine sequences responses. ST_IDLE holds while no request arrives. A request moves it to ST_RESP, where the registered result is presented for one cycle. A further request keeps it in ST_RESP, and no request returns it to ST_IDLE.

Top module: `assoc_xlate_buf`

## Requirements
- R1: After reset, rsp_valid is 0; fsr, far, tag_access and used_mask are all zero; every entry is invalid, so any translated lookup misses.
- R2: A request sampled at a clock edge gives rsp_valid = 1 after that edge, with exactly one of rsp_ok, rsp_miss, rsp_fault, rsp_prot set. A cycle without a request gives rsp_valid = 0 after the edge.
- R3: An entry's 2-bit size code picks the lowest virtual bit it compares: code 0 compares from bit 13 (8 KB), 1 from bit 16 (64 KB), 2 from bit 19 (512 KB), 3 from bit 22 (4 MB), up to bit 63.
- R4: An entry hits only when it is valid, the masked tag equals the masked address, and it is global or its context equals the selected context.
- R5: Context select: req_ctx_sel 0 takes pri_ctx, 1 takes sec_ctx, 2 or 3 takes nucleus context 0. A fetch (req_kind 3) ignores req_ctx_sel and takes pri_ctx when trap_lvl_nz is 0, else context 0. The class codes are 0 primary, 1 secondary, 2 nucleus.
- R6: A translated success returns rsp_pa = the entry's physical bits at and above the size boundary, joined with the address bits from 13 up to that boundary. Bits [12:0] of rsp_pa are 0.
- R7: When several entries hit, the lowest-numbered one supplies the result.
- R8: req_kind encodes 0 load, 1 store, 2 non-faulting load, 3 fetch. A hit raises rsp_fault in these cases: a user access to a privileged page; a non-faulting load to a side-effect page; a load or store to a no-fault-only page. A fetch checks only the privilege rule. Each cause that applies sets its own status bit.
- R9: A store that hits a non-writable page with no R8 cause raises rsp_prot, not rsp_fault.
- R10: A translated success gives read, plus write if the page is writable, for loads and stores; a fetch gets execute only. It sets the winning entry's used_mask bit.
- R11: On rsp_fault or rsp_prot, far takes the address and fsr is rewritten. Its fields are: bit 0 valid = 1; bit 1 overwrite = the old bit 0; bit 2 = privileged (not req_user); bits 4:3 context class; bit 5 store; bit 6 non-faulting load; bit 7 privilege cause; bit 8 side-effect cause; bit 9 no-fault-only cause.
- R12: On a miss or a fault, tag_access takes address bits [63:13] over the selected context in bits [12:0]. A miss leaves fsr and far unchanged.
- R13: With xlate_en = 0, a lookup succeeds with rsp_pa = address bits [40:0]. Loads and stores get read and write, a fetch gets execute only, and no state changes.
- R14: A write with wr_en installs the entry at wr_idx at the clock edge with its used bit cleared. The write wins over a same-cycle used-bit update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlate_en | input | 1 | Translation enable; 0 selects pass-through |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| trap_lvl_nz | input | 1 | Trap level is nonzero (fetch uses nucleus context) |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | $clog2(ENTRIES) | Entry index to write |
| wr_vpn | input | 51 | Virtual page bits [63:13] of the new entry |
| wr_ctx | input | 13 | Context of the new entry |
| wr_ppn | input | 28 | Physical page bits [40:13] of the new entry |
| wr_valid | input | 1 | Entry valid |
| wr_global | input | 1 | Entry matches any context |
| wr_size | input | 2 | Page-size code |
| wr_priv | input | 1 | Privileged-only page |
| wr_writable | input | 1 | Page writable |
| wr_sidefx | input | 1 | Side-effect page |
| wr_nfo | input | 1 | No-fault-only page |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2 non-faulting load, 3 fetch) |
| req_user | input | 1 | Access comes from user mode |
| req_ctx_sel | input | 2 | Context select for data accesses |
| rsp_valid | output | 1 | Result present |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Access fault |
| rsp_prot | output | 1 | Write-protection fault |
| rsp_pa | output | 41 | Physical address |
| rsp_rd | output | 1 | Read permitted |
| rsp_wr | output | 1 | Write permitted |
| rsp_ex | output | 1 | Execute permitted |
| fsr | output | 10 | Fault status word |
| far | output | 64 | Fault address |
| tag_access | output | 64 | Tag-access word |
| used_mask | output | ENTRIES | Used bit of each entry |

## Verification
The bench builds the buffer with ENTRIES = 8 and keeps the package widths (64-bit virtual, 41-bit physical, 13-bit context). With eight ways, random lookups aimed near installed pages hit, miss and collide often. That brings overlapping entries, lowest-index priority and used-bit tracking of every way within reach of a few hundred requests. Directed cases place each size code at its exact mask boundary and cover every fault combination and the overwrite flag. Random traffic mixes access kinds, modes, context selects and pass-through.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;

    localparam int VA_W     = 64;
    localparam int PA_W     = 41;
    localparam int CTX_W    = 13;
    localparam int PG_SHIFT = 13;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = PA_W - PG_SHIFT;
    localparam int SZ_STEP  = 3;
    localparam int FSR_W    = 10;

    localparam logic [1:0] CLS_PRI = 2'd0;
    localparam logic [1:0] CLS_SEC = 2'd1;
    localparam logic [1:0] CLS_NUC = 2'd2;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_STORE  = 2'd1,
        ACC_NFLOAD = 2'd2,
        ACC_FETCH  = 2'd3
    } acc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } xstate_e;

    typedef struct packed {
        logic             valid;
        logic             global;
        logic [1:0]       size;
        logic             priv;
        logic             writable;
        logic             sidefx;
        logic             nfo;
        logic             used;
        logic [PPN_W-1:0] ppn;
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
    } xent_t;

    // Bits of the virtual page number that take part in the compare.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
        vpn_mask = {VPN_W{1'b1}} << (SZ_STEP * int'(sz));
    endfunction

    // Bits of the physical page number taken from the entry.
    function automatic logic [PPN_W-1:0] ppn_mask(input logic [1:0] sz);
        ppn_mask = {PPN_W{1'b1}} << (SZ_STEP * int'(sz));
    endfunction

endpackage

// File: rtl/xbuf_match.sv
module xbuf_match
    import xbuf_pkg::*;
(
    input  logic             ent_valid,
    input  logic             ent_global,
    input  logic [1:0]       ent_size,
    input  logic [VPN_W-1:0] ent_vpn,
    input  logic [CTX_W-1:0] ent_ctx,
    input  logic [VPN_W-1:0] va_vpn,
    input  logic [CTX_W-1:0] ctx,
    output logic             hit
);
    logic [VPN_W-1:0] cmp_mask;
    logic             page_eq;
    logic             ctx_ok;

    always_comb begin
        cmp_mask = vpn_mask(ent_size);
        page_eq  = ((ent_vpn ^ va_vpn) & cmp_mask) == '0;
        ctx_ok   = ent_global || (ent_ctx == ctx);
        hit      = ent_valid && page_eq && ctx_ok;
    end
endmodule

// File: rtl/xbuf_pick.sv
module xbuf_pick #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/xbuf_classify.sv
module xbuf_classify
    import xbuf_pkg::*;
(
    input  acc_kind_e kind,
    input  logic      user,
    input  logic      pg_priv,
    input  logic      pg_writable,
    input  logic      pg_sidefx,
    input  logic      pg_nfo,
    output logic      ft_priv,
    output logic      ft_sidefx,
    output logic      ft_nfo,
    output logic      acc_fault,
    output logic      prot_fault
);
    logic is_nf;
    logic is_fetch;

    always_comb begin
        is_nf      = (kind == ACC_NFLOAD);
        is_fetch   = (kind == ACC_FETCH);
        ft_priv    = pg_priv && user;
        ft_sidefx  = is_nf && pg_sidefx;
        ft_nfo     = !is_nf && !is_fetch && pg_nfo;
        acc_fault  = ft_priv || ft_sidefx || ft_nfo;
        prot_fault = !acc_fault && (kind == ACC_STORE) && !pg_writable;
    end
endmodule

// File: rtl/assoc_xlate_buf.sv
module assoc_xlate_buf
    import xbuf_pkg::*;
#(
    parameter  int ENTRIES = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xlate_en,
    input  logic [CTX_W-1:0]   pri_ctx,
    input  logic [CTX_W-1:0]   sec_ctx,
    input  logic               trap_lvl_nz,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic [PPN_W-1:0]   wr_ppn,
    input  logic               wr_valid,
    input  logic               wr_global,
    input  logic [1:0]         wr_size,
    input  logic               wr_priv,
    input  logic               wr_writable,
    input  logic               wr_sidefx,
    input  logic               wr_nfo,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [1:0]         req_ctx_sel,
    output logic               rsp_valid,
    output logic               rsp_ok,
    output logic               rsp_miss,
    output logic               rsp_fault,
    output logic               rsp_prot,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_rd,
    output logic               rsp_wr,
    output logic               rsp_ex,
    output logic [FSR_W-1:0]   fsr,
    output logic [VA_W-1:0]    far,
    output logic [VA_W-1:0]    tag_access,
    output logic [ENTRIES-1:0] used_mask
);
    // ENTRIES is expected to be a power of two, at least 2.
    xent_t            ent_q [ENTRIES];
    xent_t            wr_ent;
    xent_t            win;
    acc_kind_e        kind;
    logic             is_fetch;
    logic [CTX_W-1:0] sel_ctx;
    logic [1:0]       sel_cls;
    logic [ENTRIES-1:0] hit_vec;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    logic             ft_priv, ft_sidefx, ft_nfo;
    logic             acc_fault, prot_fault;
    logic [PPN_W-1:0] pg_mask;
    logic [PA_W-1:0]  pa_tr;
    logic             look_ok;
    xstate_e          st_q, st_d;

    assign kind     = acc_kind_e'(req_kind);
    assign is_fetch = (kind == ACC_FETCH);

    // Context and class chosen for this access
    always_comb begin
        if (is_fetch) begin
            sel_ctx = trap_lvl_nz ? '0 : pri_ctx;
            sel_cls = trap_lvl_nz ? CLS_NUC : CLS_PRI;
        end else begin
            unique case (req_ctx_sel)
                2'd0:    begin sel_ctx = pri_ctx; sel_cls = CLS_PRI; end
                2'd1:    begin sel_ctx = sec_ctx; sel_cls = CLS_SEC; end
                default: begin sel_ctx = '0;      sel_cls = CLS_NUC; end
            endcase
        end
    end

    // One comparator per way
    for (genvar g = 0; g < ENTRIES; g++) begin : g_way
        xbuf_match u_match (
            .ent_valid  (ent_q[g].valid),
            .ent_global (ent_q[g].global),
            .ent_size   (ent_q[g].size),
            .ent_vpn    (ent_q[g].vpn),
            .ent_ctx    (ent_q[g].ctx),
            .va_vpn     (req_va[VA_W-1:PG_SHIFT]),
            .ctx        (sel_ctx),
            .hit        (hit_vec[g])
        );
        assign used_mask[g] = ent_q[g].used;
    end

    xbuf_pick #(.N(ENTRIES)) u_pick (
        .hits (hit_vec),
        .any  (any_hit),
        .idx  (win_idx)
    );

    assign win = ent_q[win_idx];

    xbuf_classify u_cls (
        .kind        (kind),
        .user        (req_user),
        .pg_priv     (win.priv),
        .pg_writable (win.writable),
        .pg_sidefx   (win.sidefx),
        .pg_nfo      (win.nfo),
        .ft_priv     (ft_priv),
        .ft_sidefx   (ft_sidefx),
        .ft_nfo      (ft_nfo),
        .acc_fault   (acc_fault),
        .prot_fault  (prot_fault)
    );

    always_comb begin
        pg_mask = ppn_mask(win.size);
        pa_tr   = {(win.ppn & pg_mask) | (req_va[PA_W-1:PG_SHIFT] & ~pg_mask),
                   {PG_SHIFT{1'b0}}};
        look_ok = req_valid && xlate_en && any_hit && !acc_fault && !prot_fault;
    end

    always_comb begin
        wr_ent          = '0;
        wr_ent.valid    = wr_valid;
        wr_ent.global   = wr_global;
        wr_ent.size     = wr_size;
        wr_ent.priv     = wr_priv;
        wr_ent.writable = wr_writable;
        wr_ent.sidefx   = wr_sidefx;
        wr_ent.nfo      = wr_nfo;
        wr_ent.ppn      = wr_ppn;
        wr_ent.vpn      = wr_vpn;
        wr_ent.ctx      = wr_ctx;
    end

    // Entry storage: used-bit update, then a write that overrides it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            if (look_ok) ent_q[win_idx].used <= 1'b1;
            if (wr_en)   ent_q[wr_idx]       <= wr_ent;
        end
    end

    // Next-state logic
    always_comb begin
        unique case (st_q)
            ST_IDLE: st_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: st_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign rsp_valid = (st_q == ST_RESP);

    // Registered result and fault bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ok     <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_prot   <= 1'b0;
            rsp_pa     <= '0;
            rsp_rd     <= 1'b0;
            rsp_wr     <= 1'b0;
            rsp_ex     <= 1'b0;
            fsr        <= '0;
            far        <= '0;
            tag_access <= '0;
        end else if (req_valid) begin
            rsp_ok    <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_prot  <= 1'b0;
            rsp_pa    <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
            if (!xlate_en) begin
                rsp_ok <= 1'b1;
                rsp_pa <= req_va[PA_W-1:0];
                rsp_rd <= !is_fetch;
                rsp_wr <= !is_fetch;
                rsp_ex <= is_fetch;
            end else if (!any_hit) begin
                rsp_miss   <= 1'b1;
                tag_access <= {req_va[VA_W-1:PG_SHIFT], sel_ctx};
            end else if (acc_fault || prot_fault) begin
                rsp_fault  <= acc_fault;
                rsp_prot   <= prot_fault;
                fsr        <= {ft_nfo, ft_sidefx, ft_priv,
                               kind == ACC_NFLOAD, kind == ACC_STORE,
                               sel_cls, !req_user, fsr[0], 1'b1};
                far        <= req_va;
                tag_access <= {req_va[VA_W-1:PG_SHIFT], sel_ctx};
            end else begin
                rsp_ok <= 1'b1;
                rsp_pa <= pa_tr;
                rsp_rd <= !is_fetch;
                rsp_wr <= !is_fetch && win.writable;
                rsp_ex <= is_fetch;
            end
        end
    end
endmodule

// File: rtl/xbuf_checker.sv
module xbuf_checker
    import xbuf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xlate_en,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_va,
    input logic             rsp_valid,
    input logic             rsp_ok,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic             rsp_prot,
    input logic [PA_W-1:0]  rsp_pa,
    input logic             rsp_wr,
    input logic [FSR_W-1:0] fsr,
    input logic [VA_W-1:0]  far
);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_ok, rsp_miss, rsp_fault, rsp_prot}) == 1);

    a_r12_miss_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_miss) |-> ($stable(fsr) && $stable(far)));

    a_r11_fault_records: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault || rsp_prot)) |-> (fsr[0] && far == $past(req_va)));

    a_r11_overwrite_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault || rsp_prot) && $past(fsr[0])) |-> fsr[1]);

    a_r13_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(!xlate_en)) |-> (rsp_ok && rsp_pa == $past(req_va[PA_W-1:0])));

    a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok && $past(xlate_en)) |-> (rsp_pa[PG_SHIFT-1:0] == '0));

    a_r10_write_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_wr) |-> rsp_ok);
endmodule

bind assoc_xlate_buf xbuf_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xlate_en  (xlate_en),
    .req_valid (req_valid),
    .req_va    (req_va),
    .rsp_valid (rsp_valid),
    .rsp_ok    (rsp_ok),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_prot  (rsp_prot),
    .rsp_pa    (rsp_pa),
    .rsp_wr    (rsp_wr),
    .fsr       (fsr),
    .far       (far)
);

// File: tb/assoc_xlate_buf_bench.sv
module assoc_xlate_buf_bench;
    import xbuf_pkg::*;

    localparam int BE = 8;
    localparam int BI = $clog2(BE);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             xlate_en, trap_lvl_nz, wr_en, req_valid, req_user;
    logic [CTX_W-1:0] pri_ctx, sec_ctx, wr_ctx;
    logic [BI-1:0]    wr_idx;
    logic [VPN_W-1:0] wr_vpn;
    logic [PPN_W-1:0] wr_ppn;
    logic             wr_valid, wr_global, wr_priv, wr_writable, wr_sidefx, wr_nfo;
    logic [1:0]       wr_size, req_kind, req_ctx_sel;
    logic [VA_W-1:0]  req_va;
    logic             rsp_valid, rsp_ok, rsp_miss, rsp_fault, rsp_prot;
    logic             rsp_rd, rsp_wr, rsp_ex;
    logic [PA_W-1:0]  rsp_pa;
    logic [FSR_W-1:0] fsr;
    logic [VA_W-1:0]  far, tag_access;
    logic [BE-1:0]    used_mask;

    assoc_xlate_buf #(.ENTRIES(BE)) u_assoc_xlate_buf (.*);

    int checks = 0;
    int failures = 0;

    xent_t            m_ent [BE];
    logic [FSR_W-1:0] m_fsr;
    logic [VA_W-1:0]  m_far, m_tag;
    logic             e_ok, e_miss, e_fault, e_prot, e_rd, e_wr, e_ex;
    logic [PA_W-1:0]  e_pa;

    task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic xent_t mk(logic [63:0] va, logic [12:0] cx, logic [40:0] pa,
                                 logic [1:0] sz, logic gl, logic pr, logic w,
                                 logic se, logic nf);
        xent_t e;
        e = '0;
        e.valid = 1'b1; e.global = gl; e.size = sz; e.priv = pr;
        e.writable = w; e.sidefx = se; e.nfo = nf;
        e.vpn = va[63:13]; e.ppn = pa[40:13]; e.ctx = cx;
        return e;
    endfunction

    function automatic logic m_hit(xent_t e, logic [63:0] va, logic [12:0] cx);
        int sh;
        sh = 3 * int'(e.size);
        return e.valid && ((va[63:13] >> sh) == (e.vpn >> sh)) && (e.global || e.ctx == cx);
    endfunction

    task automatic wr_entry(int idx, xent_t e);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = BI'(idx); wr_vpn = e.vpn; wr_ctx = e.ctx; wr_ppn = e.ppn;
        wr_valid = e.valid; wr_global = e.global; wr_size = e.size; wr_priv = e.priv;
        wr_writable = e.writable; wr_sidefx = e.sidefx; wr_nfo = e.nfo;
        @(negedge clk);
        wr_en = 1'b0;
        m_ent[idx] = e;
        m_ent[idx].used = 1'b0;
    endtask

    // Expected result from the requirements; updates the bench's own state
    task automatic model(logic [63:0] va, acc_kind_e k, logic u, logic [1:0] s,
                         logic t, logic en);
        int w;
        logic [12:0] cx;
        logic [1:0] cls;
        logic fp, fs, fn, flt, prt;
        int sh;
        xent_t e;
        w = -1;
        {e_ok, e_miss, e_fault, e_prot, e_rd, e_wr, e_ex} = '0;
        e_pa = '0;
        if (k == ACC_FETCH) begin
            cx = t ? 13'd0 : pri_ctx; cls = t ? 2'd2 : 2'd0;
        end else if (s == 2'd0) begin
            cx = pri_ctx; cls = 2'd0;
        end else if (s == 2'd1) begin
            cx = sec_ctx; cls = 2'd1;
        end else begin
            cx = 13'd0; cls = 2'd2;
        end
        if (!en) begin
            e_ok = 1'b1; e_pa = va[40:0];
            e_rd = (k != ACC_FETCH); e_wr = (k != ACC_FETCH); e_ex = (k == ACC_FETCH);
            return;
        end
        for (int i = BE - 1; i >= 0; i--) if (m_hit(m_ent[i], va, cx)) w = i;
        if (w < 0) begin
            e_miss = 1'b1;
            m_tag = {va[63:13], cx};
            return;
        end
        e = m_ent[w];
        fp = e.priv && u;
        fs = (k == ACC_NFLOAD) && e.sidefx;
        fn = (k == ACC_LOAD || k == ACC_STORE) && e.nfo;
        flt = fp || fs || fn;
        prt = !flt && (k == ACC_STORE) && !e.writable;
        if (flt || prt) begin
            e_fault = flt; e_prot = prt;
            m_fsr = {fn, fs, fp, k == ACC_NFLOAD, k == ACC_STORE, cls, !u, m_fsr[0], 1'b1};
            m_far = va;
            m_tag = {va[63:13], cx};
        end else begin
            sh = 3 * int'(e.size);
            e_ok = 1'b1;
            e_pa = {((e.ppn >> sh) << sh) | (va[40:13] & ((28'd1 << sh) - 28'd1)), 13'd0};
            e_rd = (k != ACC_FETCH);
            e_wr = (k != ACC_FETCH) && e.writable;
            e_ex = (k == ACC_FETCH);
            m_ent[w].used = 1'b1;
        end
    endtask

    task automatic do_req(string r, logic [63:0] va, acc_kind_e k, logic u,
                          logic [1:0] s, logic t, logic en);
        logic [BE-1:0] um;
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_kind = k; req_user = u;
        req_ctx_sel = s; trap_lvl_nz = t; xlate_en = en;
        model(va, k, u, s, t, en);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < BE; i++) um[i] = m_ent[i].used;
        chk(r, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(r, "outcome ok/miss/fault/prot", 64'({rsp_ok, rsp_miss, rsp_fault, rsp_prot}),
            64'({e_ok, e_miss, e_fault, e_prot}));
        if (e_ok) begin
            chk(r, "rsp_pa", 64'(rsp_pa), 64'(e_pa));
            chk(r, "perms rd/wr/ex", 64'({rsp_rd, rsp_wr, rsp_ex}), 64'({e_rd, e_wr, e_ex}));
        end
        chk(r, "fsr", 64'(fsr), 64'(m_fsr));
        chk(r, "far", far, m_far);
        chk(r, "tag_access", tag_access, m_tag);
        chk(r, "used_mask", 64'(used_mask), 64'(um));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5EED);
        xlate_en = 1'b1; trap_lvl_nz = 1'b0; wr_en = 1'b0; req_valid = 1'b0;
        req_user = 1'b0; pri_ctx = 13'd5; sec_ctx = 13'd7; wr_ctx = '0; wr_idx = '0;
        wr_vpn = '0; wr_ppn = '0; {wr_valid, wr_global, wr_priv, wr_writable, wr_sidefx, wr_nfo} = '0;
        wr_size = '0; req_kind = '0; req_ctx_sel = '0; req_va = '0;
        for (int i = 0; i < BE; i++) m_ent[i] = '0;
        m_fsr = '0; m_far = '0; m_tag = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1", "fsr", 64'(fsr), 64'd0);
        chk("R1", "far", far, 64'd0);
        chk("R1", "tag_access", tag_access, 64'd0);
        chk("R1", "used_mask", 64'(used_mask), 64'd0);
        do_req("R1", 64'h0000_0040_0000_2000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);

        // R13: pass-through
        do_req("R13", 64'hFFFF_1234_5678_9ABC, ACC_STORE, 1'b1, 2'd0, 1'b0, 1'b0);
        do_req("R13", 64'h0000_01AB_CDEF_0123, ACC_FETCH, 1'b1, 2'd0, 1'b0, 1'b0);

        // R3 / R5 / R6 / R10: 64 KB page, context 5
        wr_entry(0, mk(64'h1000_0000, 13'd5, 41'h0_0ABC_0000, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        do_req("R3", 64'h1000_E000, ACC_LOAD, 1'b1, 2'd0, 1'b0, 1'b1);
        do_req("R3", 64'h1001_0000, ACC_LOAD, 1'b1, 2'd0, 1'b0, 1'b1);
        do_req("R5", 64'h1000_2000, ACC_LOAD, 1'b1, 2'd1, 1'b0, 1'b1);
        do_req("R5", 64'h1000_2000, ACC_STORE, 1'b0, 2'd2, 1'b0, 1'b1);
        do_req("R5", 64'h1000_2000, ACC_FETCH, 1'b0, 2'd1, 1'b1, 1'b1);
        do_req("R10", 64'h1000_4000, ACC_FETCH, 1'b1, 2'd1, 1'b0, 1'b1);
        do_req("R10", 64'h1000_6000, ACC_STORE, 1'b1, 2'd0, 1'b0, 1'b1);

        // R4 / R6: global 4 MB page
        wr_entry(1, mk(64'h2000_0000, 13'd9, 41'h1_0000_0000, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
        do_req("R4", 64'h203F_E000, ACC_LOAD, 1'b0, 2'd2, 1'b0, 1'b1);
        do_req("R6", 64'h2012_3000, ACC_LOAD, 1'b1, 2'd1, 1'b0, 1'b1);
        do_req("R3", 64'h2040_0000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);

        // R3: 512 KB and 8 KB boundaries
        wr_entry(2, mk(64'h3000_0000, 13'd5, 41'h0_0200_0000, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        do_req("R3", 64'h3007_E000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);
        do_req("R3", 64'h3008_0000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);
        wr_entry(3, mk(64'h4000_0000, 13'd7, 41'h0_0300_2000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        do_req("R3", 64'h4000_1FFF, ACC_LOAD, 1'b0, 2'd1, 1'b0, 1'b1);
        do_req("R3", 64'h4000_2000, ACC_LOAD, 1'b0, 2'd1, 1'b0, 1'b1);

        // R7: overlap, lower index wins
        wr_entry(6, mk(64'h5000_0000, 13'd5, 41'h0_0600_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        wr_entry(4, mk(64'h5000_0000, 13'd5, 41'h0_0400_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        do_req("R7", 64'h5000_0000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);

        // R8 / R9 / R11: privileged, read-only, side-effect page
        wr_entry(5, mk(64'h6000_0000, 13'd0, 41'h0_0700_0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
        do_req("R8", 64'h6000_0000, ACC_LOAD, 1'b1, 2'd0, 1'b0, 1'b1);
        do_req("R11", 64'h6000_0100, ACC_NFLOAD, 1'b0, 2'd1, 1'b0, 1'b1);
        do_req("R9", 64'h6000_0200, ACC_STORE, 1'b0, 2'd0, 1'b0, 1'b1);
        do_req("R8", 64'h6000_0300, ACC_NFLOAD, 1'b1, 2'd2, 1'b0, 1'b1);
        do_req("R8", 64'h6000_0400, ACC_FETCH, 1'b1, 2'd0, 1'b1, 1'b1);

        // R8: no-fault-only page
        wr_entry(7, mk(64'h7000_0000, 13'd5, 41'h0_0800_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
        do_req("R8", 64'h7000_0000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);
        do_req("R8", 64'h7000_0010, ACC_NFLOAD, 1'b0, 2'd0, 1'b0, 1'b1);
        do_req("R8", 64'h7000_0020, ACC_STORE, 1'b0, 2'd0, 1'b0, 1'b1);

        // R12: a miss leaves fsr/far and loads tag_access
        do_req("R12", 64'hABCD_0000_7777_1234, ACC_STORE, 1'b1, 2'd1, 1'b0, 1'b1);

        // R14: rewrite clears used
        wr_entry(0, mk(64'h0900_0000, 13'd5, 41'h0_0111_0000, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
        do_req("R14", 64'h0900_0000, ACC_LOAD, 1'b0, 2'd0, 1'b0, 1'b1);

        // R2: an idle cycle gives no response
        @(negedge clk);
        chk("R2", "rsp_valid idle", 64'(rsp_valid), 64'd0);

        // Random phase (R4 and friends)
        for (int i = 0; i < BE; i++) begin
            xent_t e;
            e = mk({41'($urandom_range(0, 15)) << 9, 10'($urandom_range(0,1023)), 13'd0},
                   13'($urandom_range(0, 3) == 0 ? 0 : ($urandom_range(0, 1) ? 5 : 7)),
                   41'({$urandom, $urandom}), 2'($urandom_range(0, 3)),
                   1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
            e.valid = ($urandom_range(0, 7) != 0);
            wr_entry(i, e);
        end
        for (int n = 0; n < 400; n++) begin
            int pick;
            logic [VPN_W-1:0] flip;
            if (n % 20 == 19) begin
                xent_t e;
                e = mk({41'($urandom_range(0, 15)) << 9, 10'($urandom_range(0,1023)), 13'd0},
                       13'($urandom_range(0, 1) ? 5 : 0), 41'({$urandom, $urandom}),
                       2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
                       1'($urandom), 1'($urandom));
                wr_entry($urandom_range(0, BE - 1), e);
            end
            pick = $urandom_range(0, BE - 1);
            flip = $urandom_range(0, 1) ? VPN_W'($urandom_range(0, 511)) : '0;
            do_req("R4", {m_ent[pick].vpn ^ flip, 13'($urandom)},
                   acc_kind_e'($urandom_range(0, 3)), 1'($urandom),
                   2'($urandom_range(0, 3)), 1'($urandom), ($urandom_range(0, 9) != 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule